// File: doc/BRIEF.md
# Serial NOR Flash Command Front End

This block is the slave side of a single-I/O SPI link that answers like a serial NOR flash device. An FPGA system clock oversamples the chip select, serial clock and serial data input. Each complete byte goes to a decoder. The first byte after chip select falls is the opcode. Later bytes are address, dummy, don't-care or parameter bytes, as the opcode requires.

The decoder answers these commands on the serial output:
- array reads, with and without a dummy byte;
- the three-byte identification read;
- the manufacturer/device ID read, whose order is picked by an address byte;
- the electronic-ID read;
- the status register read.

It also keeps a write-enable latch, accepts status register writes, and enters and leaves a deep power-down state. Read data comes from a small internal byte array, which the host system fills through a preload port.

The serial clock must stay high and low for at least 4 system clock cycles per phase. Chip select is active low. Raising chip select always ends the current command.

Top module: `spifl_top`

## Requirements
- R1: SPI mode 0. SI is taken on the rising SCLK edge, most significant bit first. SO changes only after a falling SCLK edge, so each response bit is valid at the next rising edge.
- R2: `spi_so_oe` is 0 while chip select is high and during every command, address, dummy and don't-care byte. It is 1 for every bit of a response byte.
- R3: Opcode 03h takes three address bytes, highest first. Response bytes then stream from array[address mod DEPTH]. The address increments after each byte and wraps from DEPTH-1 to 0. Address bits above the array width are ignored.
- R4: Opcode 0Bh works like 03h but takes one dummy byte after the address. SO stays disabled during the dummy byte.
- R5: Opcode 06h sets the write-enable latch (WEL). Opcode 04h clears it. Both take effect at the end of the opcode byte.
- R6: Opcode 05h returns the status byte for every following byte. The status byte is: bit 0 always 0, bit 1 = WEL, bits 7:2 = the stored value. All bits are 0 after reset.
- R7: Opcode 01h followed by one byte stores bits 7:2 of that byte and clears WEL, but only if WEL is 1. With WEL at 0 the byte is ignored.
- R8: Opcode 9Fh returns the manufacturer byte (default 3Eh), then the type byte (default 71h), then the capacity byte (default 15h). The three repeat in that order.
- R9: Opcode 90h takes two don't-care bytes and then a selector byte. Selector 00h returns the manufacturer byte first; selector 01h returns the electronic ID (default 14h) first. The two then alternate.
- R10: Opcode B9h enters power-down. In power-down, every opcode other than ABh gives no response and changes no state.
- R11: Opcode ABh leaves power-down. After three don't-care bytes it returns the electronic ID, repeated for every further byte. This holds whether or not the block was in power-down.
- R12: An opcode outside the defined set gives no response and changes neither WEL, the status bits nor the power-down state.
- R13: A rising chip select aborts the command and drops any partial byte. The next byte is decoded as an opcode.
- R14: A write on the preload port stores `pl_data` at `pl_addr`, and later reads return it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_csn | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock from master |
| spi_si | input | 1 | Serial data from master |
| spi_so | output | 1 | Serial data to master |
| spi_so_oe | output | 1 | Output enable for SO; 0 means SO is released |
| pl_we | input | 1 | Preload write strobe |
| pl_addr | input | ADDR_W | Preload byte address |
| pl_data | input | 8 | Preload byte |

## Verification
The bound checker watches four things on every cycle: that SO moves only on a detected falling edge, that the output enable and decoder phase return to idle once chip select is high, that WEL only moves at byte boundaries, and that WEL holds steady through power-down. It also checks that a change to the status bits always comes with WEL falling. Which byte values come out belongs to the bench scenarios: data from the array at several start addresses including the wrap, the dummy-byte offset, both ID orders, the repeating status byte, and the aborted or ignored commands, which are checked afterwards through the status read.

// File: rtl/spifl_pkg.sv
package spifl_pkg;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_FAST = 8'h0B;
  localparam logic [7:0] OP_REMS = 8'h90;
  localparam logic [7:0] OP_RDID = 8'h9F;
  localparam logic [7:0] OP_RES  = 8'hAB;
  localparam logic [7:0] OP_DPD  = 8'hB9;

  typedef enum logic [3:0] {
    PH_OPC,    // waiting for opcode
    PH_ADDR,   // three address bytes
    PH_DUMMY,  // one dummy byte
    PH_MEM,    // streaming array data
    PH_PRE,    // don't-care / selector bytes
    PH_ID,     // three-byte identification cycle
    PH_PAIR,   // alternating two-byte ID
    PH_REPEAT, // same byte every time
    PH_WRSR,   // status value byte
    PH_SKIP    // ignore until chip select rises
  } phase_t;
endpackage

// File: rtl/spifl_rx.sv
module spifl_rx (
  input  logic       clk,
  input  logic       rst,
  input  logic       sclk,
  input  logic       csn,
  input  logic       si,
  output logic       cs_act,
  output logic       sclk_fall,
  output logic       byte_done,
  output logic [7:0] byte_val
);
  logic sck1, sck2, sck3, cs1, cs2, si1, si2;
  logic [6:0] sh_q;
  logic [2:0] bcnt_q;
  logic rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck1 <= 1'b0; sck2 <= 1'b0; sck3 <= 1'b0;
      cs1  <= 1'b1; cs2  <= 1'b1;
      si1  <= 1'b0; si2  <= 1'b0;
    end else begin
      sck1 <= sclk; sck2 <= sck1; sck3 <= sck2;
      cs1  <= csn;  cs2  <= cs1;
      si1  <= si;   si2  <= si1;
    end
  end

  assign cs_act    = ~cs2;
  assign rise      = sck2 & ~sck3;
  assign sclk_fall = cs_act & ~sck2 & sck3;

  always_ff @(posedge clk) begin
    if (rst || !cs_act) begin
      sh_q   <= '0;
      bcnt_q <= '0;
    end else if (rise) begin
      sh_q   <= {sh_q[5:0], si2};
      bcnt_q <= bcnt_q + 3'd1;
    end
  end

  assign byte_done = cs_act & rise & (bcnt_q == 3'd7);
  assign byte_val  = {sh_q, si2};
endmodule

// File: rtl/spifl_tx.sv
module spifl_tx (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_act,
  input  logic       sclk_fall,
  input  logic       load,
  input  logic [7:0] load_byte,
  output logic       so,
  output logic       so_oe
);
  logic [7:0] sh_q;
  logic [2:0] cnt_q;
  logic       valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      so <= 1'b0;
    end else if (cs_act && sclk_fall && valid_q) begin
      so <= sh_q[7];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !cs_act) begin
      sh_q    <= '0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
      so_oe   <= 1'b0;
    end else begin
      if (sclk_fall) begin
        if (valid_q) begin
          sh_q  <= {sh_q[6:0], 1'b0};
          cnt_q <= cnt_q + 3'd1;
          so_oe <= 1'b1;
          if (cnt_q == 3'd7) valid_q <= 1'b0;
        end else begin
          so_oe <= 1'b0;
        end
      end
      if (load) begin
        sh_q    <= load_byte;
        cnt_q   <= '0;
        valid_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/spifl_ram.sv
module spifl_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/spifl_top.sv
module spifl_top
  import spifl_pkg::*;
#(
  parameter int         ADDR_W  = 8,
  parameter logic [7:0] MFR_ID  = 8'h3E,
  parameter logic [7:0] TYPE_ID = 8'h71,
  parameter logic [7:0] CAP_ID  = 8'h15,
  parameter logic [7:0] ELEC_ID = 8'h14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_csn,
  input  logic              spi_sclk,
  input  logic              spi_si,
  output logic              spi_so,
  output logic              spi_so_oe,
  input  logic              pl_we,
  input  logic [ADDR_W-1:0] pl_addr,
  input  logic [7:0]        pl_data
);
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  logic              cs_act, sclk_fall, byte_done;
  logic [7:0]        byte_val, mem_q, fix_q;
  phase_t            phase_q;
  logic [7:0]        cmd_q;
  logic [1:0]        cnt_q, id_sel_q;
  logic [ADDR_W-1:0] addr_q;
  logic              wel_q, pd_q, tog_q;
  logic [5:0]        sr_hi_q;
  logic              ld_req_q, ld_d1_q, ld_mem_q;
  logic [7:0]        status_b;

  assign status_b = {sr_hi_q, wel_q, 1'b0};

  spifl_rx u_rx (
    .clk(clk), .rst(rst), .sclk(spi_sclk), .csn(spi_csn), .si(spi_si),
    .cs_act(cs_act), .sclk_fall(sclk_fall),
    .byte_done(byte_done), .byte_val(byte_val)
  );

  spifl_ram #(.AW(ADDR_W), .DW(8)) u_ram (
    .clk(clk), .we(pl_we), .waddr(pl_addr), .wdata(pl_data),
    .raddr(addr_q), .rdata(mem_q)
  );

  spifl_tx u_tx (
    .clk(clk), .rst(rst), .cs_act(cs_act), .sclk_fall(sclk_fall),
    .load(ld_d1_q), .load_byte(ld_mem_q ? mem_q : fix_q),
    .so(spi_so), .so_oe(spi_so_oe)
  );

  // persistent state: survives chip select
  always_ff @(posedge clk) begin
    if (rst) begin
      wel_q   <= 1'b0;
      pd_q    <= 1'b0;
      sr_hi_q <= '0;
    end else if (byte_done) begin
      if (phase_q == PH_OPC) begin
        if (!pd_q) begin
          if (byte_val == OP_WREN) wel_q <= 1'b1;
          if (byte_val == OP_WRDI) wel_q <= 1'b0;
          if (byte_val == OP_DPD)  pd_q  <= 1'b1;
        end
        if (byte_val == OP_RES) pd_q <= 1'b0;
      end else if (phase_q == PH_WRSR && wel_q) begin
        sr_hi_q <= byte_val[7:2];
        wel_q   <= 1'b0;
      end
    end
  end

  // per-command sequencing
  always_ff @(posedge clk) begin
    if (rst || !cs_act) begin
      phase_q  <= PH_OPC;
      cmd_q    <= '0;
      cnt_q    <= '0;
      id_sel_q <= '0;
      tog_q    <= 1'b0;
      addr_q   <= '0;
      fix_q    <= '0;
      ld_req_q <= 1'b0;
      ld_d1_q  <= 1'b0;
      ld_mem_q <= 1'b0;
    end else begin
      ld_d1_q  <= ld_req_q;
      ld_req_q <= 1'b0;
      if (byte_done) begin
        case (phase_q)
          PH_OPC: begin
            cmd_q <= byte_val;
            cnt_q <= '0;
            if (pd_q && byte_val != OP_RES) begin
              phase_q <= PH_SKIP;
            end else begin
              case (byte_val)
                OP_READ, OP_FAST: phase_q <= PH_ADDR;
                OP_RDSR: begin
                  phase_q  <= PH_REPEAT;
                  fix_q    <= status_b;
                  ld_mem_q <= 1'b0;
                  ld_req_q <= 1'b1;
                end
                OP_WRSR: phase_q <= PH_WRSR;
                OP_RDID: begin
                  phase_q  <= PH_ID;
                  fix_q    <= MFR_ID;
                  id_sel_q <= 2'd1;
                  ld_mem_q <= 1'b0;
                  ld_req_q <= 1'b1;
                end
                OP_REMS, OP_RES: phase_q <= PH_PRE;
                default: phase_q <= PH_SKIP;
              endcase
            end
          end
          PH_ADDR: begin
            addr_q <= ADDR_W'({addr_q, byte_val});
            cnt_q  <= cnt_q + 2'd1;
            if (cnt_q == 2'd2) begin
              if (cmd_q == OP_FAST) begin
                phase_q <= PH_DUMMY;
              end else begin
                phase_q  <= PH_MEM;
                ld_mem_q <= 1'b1;
                ld_req_q <= 1'b1;
              end
            end
          end
          PH_DUMMY: begin
            phase_q  <= PH_MEM;
            ld_mem_q <= 1'b1;
            ld_req_q <= 1'b1;
          end
          PH_MEM: begin
            addr_q   <= addr_q + ADDR_ONE;
            ld_req_q <= 1'b1;
          end
          PH_PRE: begin
            cnt_q <= cnt_q + 2'd1;
            if (cnt_q == 2'd2) begin
              ld_mem_q <= 1'b0;
              ld_req_q <= 1'b1;
              if (cmd_q == OP_REMS) begin
                phase_q <= PH_PAIR;
                tog_q   <= byte_val[0];
                fix_q   <= byte_val[0] ? ELEC_ID : MFR_ID;
              end else begin
                phase_q <= PH_REPEAT;
                fix_q   <= ELEC_ID;
              end
            end
          end
          PH_ID: begin
            ld_req_q <= 1'b1;
            case (id_sel_q)
              2'd1:    begin fix_q <= TYPE_ID; id_sel_q <= 2'd2; end
              2'd2:    begin fix_q <= CAP_ID;  id_sel_q <= 2'd0; end
              default: begin fix_q <= MFR_ID;  id_sel_q <= 2'd1; end
            endcase
          end
          PH_PAIR: begin
            ld_req_q <= 1'b1;
            tog_q    <= ~tog_q;
            fix_q    <= tog_q ? MFR_ID : ELEC_ID;
          end
          PH_REPEAT: ld_req_q <= 1'b1;
          PH_WRSR:   phase_q  <= PH_SKIP;
          default:   ;
        endcase
      end
    end
  end
endmodule

// File: rtl/spifl_chk.sv
module spifl_chk
  import spifl_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       cs_act,
  input logic       sclk_fall,
  input logic       byte_done,
  input logic       so,
  input logic       so_oe,
  input logic       pd,
  input logic       wel,
  input logic [5:0] sr_hi,
  input phase_t     phase
);
  AST_SO_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !sclk_fall |=> $stable(so)); // R1

  AST_OE_IDLE_NO_CS: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !so_oe); // R2

  AST_WEL_AT_BYTE_END: assert property (@(posedge clk) disable iff (rst)
    !$stable(wel) |-> $past(byte_done)); // R5

  AST_SR_WRITE_DROPS_WEL: assert property (@(posedge clk) disable iff (rst)
    !$stable(sr_hi) |-> $fell(wel)); // R7

  AST_PD_FREEZES_WEL: assert property (@(posedge clk) disable iff (rst)
    pd |=> (!pd || $stable(wel))); // R10

  AST_OPC_AFTER_DESELECT: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> phase == PH_OPC); // R13
endmodule

bind spifl_top spifl_chk u_chk (
  .clk(clk), .rst(rst), .cs_act(cs_act), .sclk_fall(sclk_fall),
  .byte_done(byte_done), .so(spi_so), .so_oe(spi_so_oe),
  .pd(pd_q), .wel(wel_q), .sr_hi(sr_hi_q), .phase(phase_q)
);

// File: tb/tb_spifl_top.sv
`timescale 1ns/1ps
module tb_spifl_top;
  localparam int AW   = 8;
  localparam int HALF = 6;
  localparam logic [7:0] MFR = 8'h3E, TYP = 8'h71, CAP = 8'h15, ELEC = 8'h14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic csn = 1'b1, sclk = 1'b0, si = 1'b0;
  logic so, so_oe;
  logic pl_we = 1'b0;
  logic [AW-1:0] pl_addr = '0;
  logic [7:0] pl_data = '0;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  spifl_top #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .spi_csn(csn), .spi_sclk(sclk), .spi_si(si),
    .spi_so(so), .spi_so_oe(so_oe),
    .pl_we(pl_we), .pl_addr(pl_addr), .pl_data(pl_data)
  );

  function automatic logic [7:0] memf(input int a);
    return 8'((a * 37 + 11) & 8'hFF);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sel();
    @(negedge clk) csn = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic desel();
    repeat (4) @(negedge clk);
    csn = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  // one byte: rx is what SO showed at each rising edge
  task automatic xb(input logic [7:0] tx, output logic [7:0] rx,
                    output bit oe_all, output bit oe_any);
    oe_all = 1'b1; oe_any = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      si = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = so;
      oe_all &= so_oe; oe_any |= so_oe;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic bits(input int n);
    for (int i = 0; i < n; i++) begin
      si = 1'b0;
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] r; bit a, b;
    sel(); xb(op, r, a, b); desel();
  endtask

  task automatic status(input string tag, input logic [7:0] exp);
    logic [7:0] r; bit a, b;
    sel(); xb(8'h05, r, a, b);
    xb(8'h00, r, a, b);
    chk(tag, r, exp);
    chk({tag, " oe"}, a, 1);
    desel();
  endtask

  task automatic rd(input logic [7:0] op, input logic [23:0] ad, input int n);
    logic [7:0] r; bit a, b;
    sel();
    xb(op, r, a, b); chk("R2 opcode oe", b, 0);
    xb(ad[23:16], r, a, b); xb(ad[15:8], r, a, b); xb(ad[7:0], r, a, b);
    chk("R2 address oe", b, 0);
    if (op == 8'h0B) begin
      xb(8'h00, r, a, b); chk("R4 dummy oe", b, 0);
    end
    for (int k = 0; k < n; k++) begin
      xb(8'h00, r, a, b);
      chk(op == 8'h0B ? "R4 data" : "R3 data", r, memf((ad[7:0] + k) % 256));
      chk("R2 data oe", a, 1);
    end
    desel();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R13 watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r; bit a, b;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R2 reset oe", so_oe, 0);
    // R14 preload the whole array
    for (int i = 0; i < 256; i++) begin
      pl_we = 1'b1; pl_addr = 8'(i); pl_data = memf(i);
      @(negedge clk);
    end
    pl_we = 1'b0;
    status("R6 reset status", 8'h00);

    // R1 R3 reads at several starts, upper address bits ignored, wrap
    rd(8'h03, 24'h000000, 4);
    rd(8'h03, 24'hA5123C, 5);
    rd(8'h03, 24'h00FFFD, 6);
    // R4 fast read
    rd(8'h0B, 24'h7F0080, 4);
    rd(8'h0B, 24'h0000FE, 3);

    // R5 R6 WEL and repeating status
    cmd1(8'h06);
    sel(); xb(8'h05, r, a, b);
    for (int k = 0; k < 3; k++) begin
      xb(8'h00, r, a, b); chk("R6 repeat status", r, 8'h02);
    end
    desel();
    // R7 write with WEL
    sel(); xb(8'h01, r, a, b); xb(8'hA7, r, a, b); desel();
    status("R7 sr write", 8'hA4);
    // R7 write without WEL ignored
    sel(); xb(8'h01, r, a, b); xb(8'h10, r, a, b); desel();
    status("R7 sr locked", 8'hA4);
    // R5 clear
    cmd1(8'h06); cmd1(8'h04);
    status("R5 wrdi", 8'hA4);

    // R8 ID cycle
    sel(); xb(8'h9F, r, a, b);
    for (int k = 0; k < 6; k++) begin
      xb(8'h00, r, a, b);
      chk("R8 id", r, (k % 3 == 0) ? MFR : (k % 3 == 1) ? TYP : CAP);
    end
    desel();
    // R9 both orders
    for (int s = 0; s < 2; s++) begin
      sel(); xb(8'h90, r, a, b); xb(8'hFF, r, a, b); xb(8'hFF, r, a, b);
      xb(8'(s), r, a, b); chk("R9 selector oe", b, 0);
      for (int k = 0; k < 4; k++) begin
        xb(8'h00, r, a, b);
        chk("R9 pair", r, (((k + s) % 2) == 0) ? MFR : ELEC);
      end
      desel();
    end

    // R12 undefined opcode with WEL set
    cmd1(8'h06);
    sel(); xb(8'h77, r, a, b); xb(8'h00, r, a, b); xb(8'h00, r, a, b);
    chk("R12 no response", b, 0); desel();
    status("R12 state kept", 8'hA6);

    // R10 power-down
    cmd1(8'hB9);
    cmd1(8'h04);
    sel(); xb(8'h05, r, a, b); xb(8'h00, r, a, b);
    chk("R10 status silent", b, 0); desel();
    sel(); xb(8'h9F, r, a, b); xb(8'h00, r, a, b);
    chk("R10 id silent", b, 0); desel();
    // R11 release with ID
    sel(); xb(8'hAB, r, a, b);
    for (int k = 0; k < 3; k++) xb(8'h00, r, a, b);
    chk("R11 dc oe", b, 0);
    for (int k = 0; k < 2; k++) begin
      xb(8'h00, r, a, b); chk("R11 elec id", r, ELEC);
    end
    desel();
    status("R10 wel kept", 8'hA6);
    sel(); xb(8'hAB, r, a, b); xb(8'h00, r, a, b); xb(8'h00, r, a, b);
    xb(8'h00, r, a, b); xb(8'h00, r, a, b); desel();
    chk("R11 awake id", r, ELEC);

    // R13 abort inside status write data byte
    sel(); xb(8'h01, r, a, b); bits(4); desel();
    status("R13 partial write", 8'hA6);
    // R13 abort inside address
    sel(); xb(8'h03, r, a, b); xb(8'h00, r, a, b); xb(8'h00, r, a, b); desel();
    status("R13 after read abort", 8'hA6);

    // R14 preload overwrite
    @(negedge clk) pl_we = 1'b1; pl_addr = 8'h10; pl_data = 8'hEE;
    @(negedge clk) pl_we = 1'b0;
    sel(); xb(8'h03, r, a, b); xb(8'h00, r, a, b); xb(8'h00, r, a, b);
    xb(8'h10, r, a, b); xb(8'h00, r, a, b); chk("R14 preload", r, 8'hEE);
    xb(8'h00, r, a, b); chk("R14 next", r, memf(8'h11));
    desel();
    chk("R2 idle oe", so_oe, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule